// File: doc/BRIEF.md
# Flash Mode Controller

This block decides which of three operating modes an on-chip flash array is in: plain read, burst assembly, or command execution. It watches a simple word-addressed write bus into the flash space and decodes multi-write command sequences. Each sequence is two unlock writes followed by a command write. Read accesses go straight to the array with a one-cycle registered return. They are refused only while a self-timed operation runs, and the `busy` output shows when that is the case.

In burst mode, every bus write that is not a control write lands in a page-sized assembly buffer. A store command then programs the whole page in one self-timed cycle. Programming only clears bits, so each array word becomes its old value ANDed with the buffer word. The store is carried out only when exactly one page of words was collected. Otherwise the controller raises `burst_err` and returns to read mode. A sector erase, confirmed at the lowest address of the sector, sets every word of that sector to all ones. The array is a register model that finishes each operation after a fixed latency and then pulses done.

States:
- `ST_READ`: plain read mode.
- `ST_UNL1` and `ST_UNL2`: first and second unlock write seen.
- `ST_ERASE_ARM`: waiting for the erase confirm write.
- `ST_BURST`: burst assembly.
- `ST_PROG` and `ST_ERASE`: busy.

Transitions:
- unlock-1: `ST_READ`→`ST_UNL1`.
- unlock-2: `ST_UNL1`→`ST_UNL2`.
- enter-burst: `ST_UNL2`→`ST_BURST`.
- erase-setup: `ST_UNL2`→`ST_ERASE_ARM`.
- erase-go: `ST_ERASE_ARM`→`ST_ERASE`.
- store-ok: `ST_BURST`→`ST_PROG`.
- store-bad: `ST_BURST`→`ST_READ`, setting `burst_err`.
- sequence-error: any unlock or arm state back to `ST_READ`.
- reset-to-read: any non-busy state back to `ST_READ`.
- op-done: `ST_PROG` or `ST_ERASE` back to `ST_READ`.

Top module: `flash_mode_ctrl`

## Requirements
- R1: Addressing and reset state.
  - The bus address is a byte address. The array word index is `bus_addr[ADDR_W-1:1]`, and bit 0 is never looked at, including when special addresses are matched.
  - The first special address K1 is the highest word index. The second, K2, is the word index one below it.
  - On the first cycle after reset is released, the block is in read mode with `busy`=0, `burst_err`=0 and `burst_mode`=0, and every array word reads 16'hFFFF.
- R2: In read mode, a cycle with `bus_re`=1 returns the addressed word on `bus_rdata`, with `bus_rvalid`=1, after the next clock edge.
- R3: Unlock sequence.
  - A command sequence is: K1 written with 16'h00AA, then K2 written with 16'h0055, then K1 written with a command code.
  - A write with the wrong address or the wrong data in an unlock step returns the block to read mode. A later command write then has no effect.
- R4: Command code 16'h00A0 enters burst mode (`burst_mode`=1). Each following write fills the next buffer slot in order. The target page is the page of the first word written.
- R5: Successful store.
  - In burst mode, writing 16'h00B0 to K1 with exactly BURST_WORDS words collected starts programming. Each target word becomes its old value AND the buffer word.
  - `busy` is 1 for exactly OP_LAT+1 cycles, and then the block is back in read mode.
- R6: Failed store.
  - A store with any other word count starts nothing. It sets `burst_err`=1 and returns to read mode, and the array is unchanged.
  - The word counter saturates at BURST_WORDS+1, so overflow stays detectable.
- R7: Reads in burst mode return array data normally.
- R8: While `busy`=1, reads give no `bus_rvalid` and writes do not advance any sequence.
- R9: Sector erase.
  - Command code 16'h0080 followed by a write of 16'h0030 to the lowest address of a sector erases that sector to 16'hFFFF.
  - A confirm write to any other address of the sector is a sequence error: nothing is erased and `busy` stays 0.
- R10: Writing 16'h00F0 to K1 in any non-busy state returns to read mode and clears `burst_err`. Inside burst mode it discards the buffer.
- R11: `burst_err` is cleared by the next accepted enter-burst or erase-go.
- R12: Any number of idle cycles between the writes of a sequence neither aborts nor alters it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe into flash space |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after an accepted read |
| busy | output | 1 | Self-timed operation running |
| burst_err | output | 1 | Last store had a wrong word count |
| burst_mode | output | 1 | Burst assembly active |

## Verification
The bench builds the block with ADDR_W=5, BURST_WORDS=4, OP_LAT=6 and DATA_W=16. That gives sixteen words in four sectors, so every word can be read back after every operation, and every page can be programmed and every sector erased. It sweeps the store word count from zero to seven, which reaches both the short-page error and the saturating overflow count. It tries every non-base confirm offset of a sector. With the short latency, the reads and writes issued while busy fall inside the busy window and can be checked, along with its exact length.

// File: rtl/fmc_pkg.sv
package fmc_pkg;

    typedef enum logic [2:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_ERASE_ARM,
        ST_BURST,
        ST_PROG,
        ST_ERASE
    } fmc_state_e;

    localparam logic [7:0] CODE_KEY_A   = 8'hAA;
    localparam logic [7:0] CODE_KEY_B   = 8'h55;
    localparam logic [7:0] CODE_BURST   = 8'hA0;
    localparam logic [7:0] CODE_ERASE   = 8'h80;
    localparam logic [7:0] CODE_CONFIRM = 8'h30;
    localparam logic [7:0] CODE_STORE   = 8'hB0;
    localparam logic [7:0] CODE_RTR     = 8'hF0;

endpackage

// File: rtl/fmc_burst_buf.sv
module fmc_burst_buf #(
    parameter int WORDS  = 32,
    parameter int DATA_W = 16,
    localparam int CNT_W = $clog2(WORDS + 2)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     wr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [CNT_W-1:0]         cnt,
    output logic [WORDS*DATA_W-1:0]  words_flat
);

    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(WORDS + 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (wr && cnt != CNT_SAT) begin
            cnt <= cnt + 1'b1;
        end
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_slot
        logic [DATA_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (wr && cnt == CNT_W'(g)) begin
                slot_q <= wdata;
            end
        end
        assign words_flat[g*DATA_W +: DATA_W] = slot_q;
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_SAT);  // R6

    AST_CNT_HOLDS_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_SAT && !clr) |=> cnt == CNT_SAT);  // R6

endmodule

// File: rtl/fmc_array.sv
module fmc_array #(
    parameter int IDX_W      = 7,
    parameter int DATA_W     = 16,
    parameter int PAGE_WORDS = 32,
    parameter int OP_LAT     = 8,
    localparam int WORDS  = 2 ** IDX_W,
    localparam int PG_B   = $clog2(PAGE_WORDS),
    localparam int SECT_W = IDX_W - PG_B,
    localparam int TMR_W  = $clog2(OP_LAT + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en,
    input  logic [IDX_W-1:0]              rd_idx,
    output logic [DATA_W-1:0]             rd_data,
    input  logic                          op_start,
    input  logic                          op_erase,
    input  logic [SECT_W-1:0]             op_sect,
    input  logic [PAGE_WORDS*DATA_W-1:0]  prog_flat,
    output logic                          op_done
);

    logic [DATA_W-1:0] cells [WORDS];
    logic              run_q;
    logic              erase_q;
    logic [SECT_W-1:0] sect_q;
    logic [TMR_W-1:0]  tmr_q;
    logic              apply;

    assign apply = run_q && (tmr_q == TMR_W'(OP_LAT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            erase_q <= 1'b0;
            sect_q  <= '0;
            tmr_q   <= '0;
            op_done <= 1'b0;
        end else begin
            op_done <= apply;
            if (op_start) begin
                run_q   <= 1'b1;
                erase_q <= op_erase;
                sect_q  <= op_sect;
                tmr_q   <= '0;
            end else if (apply) begin
                run_q <= 1'b0;
            end else if (run_q) begin
                tmr_q <= tmr_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) begin
                cells[w] <= '1;
            end
        end else if (apply) begin
            for (int w = 0; w < WORDS; w++) begin
                if (SECT_W'(w >> PG_B) == sect_q) begin
                    cells[w] <= erase_q ? '1
                              : (cells[w] & prog_flat[(w % PAGE_WORDS)*DATA_W +: DATA_W]);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data <= cells[rd_idx];
        end
    end

    AST_NO_START_WHILE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> !run_q);  // R8

    AST_DONE_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);  // R5

endmodule

// File: rtl/flash_mode_ctrl.sv
module flash_mode_ctrl
    import fmc_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int BURST_WORDS = 32,
    parameter int OP_LAT      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              busy,
    output logic              burst_err,
    output logic              burst_mode
);

    localparam int IDX_W     = ADDR_W - 1;
    localparam int NUM_WORDS = 2 ** IDX_W;
    localparam int PG_B      = $clog2(BURST_WORDS);
    localparam int SECT_W    = IDX_W - PG_B;
    localparam int CNT_W     = $clog2(BURST_WORDS + 2);
    localparam logic [IDX_W-1:0] K1_IDX = IDX_W'(NUM_WORDS - 1);
    localparam logic [IDX_W-1:0] K2_IDX = IDX_W'(NUM_WORDS - 2);

    function automatic logic is_code(input logic [DATA_W-1:0] d, input logic [7:0] c);
        return d == DATA_W'(c);
    endfunction

    fmc_state_e state, nxt;

    logic [IDX_W-1:0]  idx;
    logic [SECT_W-1:0] idx_sect;
    logic              at_base, hit_k1, hit_k2, is_rtr;
    logic              op_start, op_erase, op_done;
    logic              buf_clr, buf_wr, buer_set, buer_clr;
    logic [SECT_W-1:0] tgt_sect_q, op_sect;
    logic [CNT_W-1:0]  buf_cnt;
    logic [BURST_WORDS*DATA_W-1:0] buf_flat;
    logic              rd_en;

    assign idx      = bus_addr[ADDR_W-1:1];
    assign idx_sect = idx[IDX_W-1:PG_B];
    assign at_base  = (idx[PG_B-1:0] == '0);
    assign hit_k1   = (idx == K1_IDX);
    assign hit_k2   = (idx == K2_IDX);
    assign is_rtr   = hit_k1 && is_code(bus_wdata, CODE_RTR);

    // next state and control strobes
    always_comb begin
        nxt      = state;
        op_start = 1'b0;
        op_erase = 1'b0;
        buf_clr  = 1'b0;
        buf_wr   = 1'b0;
        buer_set = 1'b0;
        buer_clr = 1'b0;
        unique case (state)
            ST_READ: begin
                if (bus_we) begin
                    if (is_rtr) buer_clr = 1'b1;
                    else if (hit_k1 && is_code(bus_wdata, CODE_KEY_A)) nxt = ST_UNL1;
                end
            end
            ST_UNL1: begin
                if (bus_we) begin
                    if (hit_k2 && is_code(bus_wdata, CODE_KEY_B)) begin
                        nxt = ST_UNL2;
                    end else begin
                        nxt      = ST_READ;
                        buer_clr = is_rtr;
                    end
                end
            end
            ST_UNL2: begin
                if (bus_we) begin
                    if (hit_k1 && is_code(bus_wdata, CODE_BURST)) begin
                        nxt      = ST_BURST;
                        buf_clr  = 1'b1;
                        buer_clr = 1'b1;
                    end else if (hit_k1 && is_code(bus_wdata, CODE_ERASE)) begin
                        nxt = ST_ERASE_ARM;
                    end else begin
                        nxt      = ST_READ;
                        buer_clr = is_rtr;
                    end
                end
            end
            ST_ERASE_ARM: begin
                if (bus_we) begin
                    if (is_code(bus_wdata, CODE_CONFIRM) && at_base) begin
                        nxt      = ST_ERASE;
                        op_start = 1'b1;
                        op_erase = 1'b1;
                        buer_clr = 1'b1;
                    end else begin
                        nxt      = ST_READ;
                        buer_clr = is_rtr;
                    end
                end
            end
            ST_BURST: begin
                if (bus_we) begin
                    if (hit_k1 && is_code(bus_wdata, CODE_STORE)) begin
                        if (buf_cnt == CNT_W'(BURST_WORDS)) begin
                            nxt      = ST_PROG;
                            op_start = 1'b1;
                        end else begin
                            nxt      = ST_READ;
                            buer_set = 1'b1;
                        end
                    end else if (is_rtr) begin
                        nxt      = ST_READ;
                        buer_clr = 1'b1;
                    end else begin
                        buf_wr = 1'b1;
                    end
                end
            end
            ST_PROG, ST_ERASE: begin
                if (op_done) nxt = ST_READ;
            end
            default: nxt = ST_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_READ;
            burst_err  <= 1'b0;
            tgt_sect_q <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            state      <= nxt;
            bus_rvalid <= rd_en;
            if (buer_set)      burst_err <= 1'b1;
            else if (buer_clr) burst_err <= 1'b0;
            if (buf_wr && buf_cnt == '0) tgt_sect_q <= idx_sect;
        end
    end

    assign busy       = (state == ST_PROG) || (state == ST_ERASE);
    assign burst_mode = (state == ST_BURST);
    assign rd_en      = bus_re && !busy;
    assign op_sect    = op_erase ? idx_sect : tgt_sect_q;

    fmc_burst_buf #(.WORDS(BURST_WORDS), .DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr(buf_wr),
        .wdata(bus_wdata), .cnt(buf_cnt), .words_flat(buf_flat)
    );

    fmc_array #(.IDX_W(IDX_W), .DATA_W(DATA_W), .PAGE_WORDS(BURST_WORDS), .OP_LAT(OP_LAT)) u_arr (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(idx), .rd_data(bus_rdata),
        .op_start(op_start), .op_erase(op_erase), .op_sect(op_sect),
        .prog_flat(buf_flat), .op_done(op_done)
    );

    AST_PROG_ONLY_FULL_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && !op_erase) |-> buf_cnt == CNT_W'(BURST_WORDS));  // R5

    AST_ERASE_AT_SECTOR_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_erase) |-> bus_addr[PG_B:1] == '0);  // R9

    AST_DONE_RELEASES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !busy);  // R5

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_done) |=> busy);  // R8

    AST_BUSY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !bus_rvalid);  // R8

    AST_BUER_FROM_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_err) |-> $past(state == ST_BURST));  // R6

endmodule

// File: tb/flash_mode_ctrl_tb_top.sv
module flash_mode_ctrl_tb_top;

    localparam int AW  = 5;
    localparam int DW  = 16;
    localparam int BW  = 4;
    localparam int LAT = 6;
    localparam int NW  = 16;
    localparam logic [AW-1:0] K1 = 5'h1E;
    localparam logic [AW-1:0] K2 = 5'h1C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0, bus_re = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          bus_rvalid, busy, burst_err, burst_mode;

    int total = 0;
    int fails = 0;
    bit finished = 0;
    logic [DW-1:0] mdl [NW];

    always #5 clk = ~clk;

    flash_mode_ctrl #(.ADDR_W(AW), .DATA_W(DW), .BURST_WORDS(BW), .OP_LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .busy(busy), .burst_err(burst_err), .burst_mode(burst_mode)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic v);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata; v = bus_rvalid;
    endtask

    task automatic unlock(input logic [7:0] cmd, input bit b0);
        wr(K1 | AW'(b0), 16'h00AA);
        wr(K2 | AW'(b0), 16'h0055);
        wr(K1, {8'h00, cmd});
    endtask

    task automatic sweep(input string req);
        logic [DW-1:0] d; logic v;
        for (int i = 0; i < NW; i++) begin
            rd({4'(i), 1'b0}, d, v);
            chk(v && d == mdl[i], req, {15'd0, v, d}, {15'd0, 1'b1, mdl[i]});
        end
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 100) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic prog_page(input int s, input int first_s, input logic [DW-1:0] base);
        int n;
        unlock(8'hA0, 1'b0);
        for (int i = 0; i < BW; i++) begin
            wr({2'((i == 0) ? first_s : (s + i) % 4), 2'(i), 1'b0}, base ^ DW'(i * 16'h0111));
        end
        wr(K1, 16'h00B0);
        chk(busy == 1'b1, "R5 busy after store", {31'd0, busy}, 32'd1);
        wait_idle(n);
        chk(n == LAT + 1, "R5 busy length", n, LAT + 1);
        for (int i = 0; i < BW; i++) mdl[first_s*BW + i] &= base ^ DW'(i * 16'h0111);
    endtask

    initial begin
        int n;
        logic [DW-1:0] d; logic v;
        for (int i = 0; i < NW; i++) mdl[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !burst_err && !burst_mode, "R1 reset state",
            {29'd0, busy, burst_err, burst_mode}, 32'd0);
        sweep("R1 erased after reset / R2 read");

        // R5: program every page, each with its own pattern
        for (int s = 0; s < 4; s++) prog_page(s, s, ~(16'h0001 << (s * 4)));
        sweep("R5 program sweep");
        // R5: second program ANDs into the old content
        prog_page(2, 2, 16'h5A5A);
        sweep("R5 AND semantics");

        // R4 target page from first word; R7 read inside burst
        unlock(8'hA0, 1'b0);
        chk(burst_mode == 1'b1, "R4 enter burst", {31'd0, burst_mode}, 32'd1);
        wr({2'd1, 2'd0, 1'b0}, 16'h0F0F);
        rd(5'h04, d, v);
        chk(v && d == mdl[2], "R7 read in burst", {15'd0, v, d}, {15'd0, 1'b1, mdl[2]});
        for (int i = 1; i < BW; i++) wr({2'd3, 2'(i), 1'b0}, 16'h0F0F ^ DW'(i));
        wr(K1, 16'h00B0);
        wait_idle(n);
        for (int i = 0; i < BW; i++) mdl[BW + i] &= 16'h0F0F ^ DW'(i);
        sweep("R4 first-address page");

        // R6 / R11 word-count sweep
        for (int c = 0; c <= 7; c++) begin
            if (c == BW) continue;
            unlock(8'hA0, 1'b0);
            chk(!burst_err, "R11 enter burst clears error", {31'd0, burst_err}, 32'd0);
            for (int i = 0; i < c; i++) wr({2'd0, 2'(i % 4), 1'b0}, 16'h0000);
            wr(K1, 16'h00B0);
            chk(burst_err && !busy && !burst_mode, "R6 bad count",
                {29'd0, burst_err, busy, burst_mode}, 32'd4);
        end
        sweep("R6 array unchanged");

        // R10 reset-to-read
        wr(K1, 16'h00F0);
        chk(!burst_err, "R10 clears error", {31'd0, burst_err}, 32'd0);
        unlock(8'hA0, 1'b0);
        wr(5'h00, 16'h0000);
        wr(5'h02, 16'h0000);
        wr(K1, 16'h00F0);
        chk(!burst_mode && !burst_err, "R10 leaves burst", {30'd0, burst_mode, burst_err}, 32'd0);
        wr(K1, 16'h00B0);
        chk(!busy, "R10 store ignored after exit", {31'd0, busy}, 32'd0);
        wr(K1, 16'h00AA);
        wr(K1, 16'h00F0);
        wr(K1, 16'h00A0);
        chk(!burst_mode, "R10 abort from unlock", {31'd0, burst_mode}, 32'd0);
        sweep("R10 array unchanged");

        // R9 non-base confirm is an error
        for (int off = 1; off < BW; off++) begin
            unlock(8'h80, 1'b0);
            wr({2'd1, 2'(off), 1'b0}, 16'h0030);
            chk(!busy, "R9 non-base rejected", {31'd0, busy}, 32'd0);
        end
        sweep("R9 nothing erased");

        // R11 erase clears error; R9 erase every sector
        unlock(8'hA0, 1'b0);
        wr(K1, 16'h00B0);
        chk(burst_err, "R6 empty store", {31'd0, burst_err}, 32'd1);
        for (int s = 0; s < 4; s++) begin
            unlock(8'h80, 1'b0);
            wr({2'(s), 2'd0, 1'(s & 1)}, 16'h0030);
            chk(busy && !burst_err, "R9 R11 erase start", {30'd0, busy, burst_err}, 32'd2);
            wait_idle(n);
            chk(n == LAT + 1, "R9 erase length", n, LAT + 1);
            for (int i = 0; i < BW; i++) mdl[s*BW + i] = 16'hFFFF;
            sweep("R9 erase sweep");
        end

        // R3 sequence mismatches and bit-0 independence
        wr(K1, 16'h00AA); wr(5'h06, 16'h0055); wr(K1, 16'h00A0);
        chk(!burst_mode, "R3 wrong address", {31'd0, burst_mode}, 32'd0);
        wr(K1, 16'h00AA); wr(K2, 16'h0054); wr(K1, 16'h00A0);
        chk(!burst_mode, "R3 wrong data", {31'd0, burst_mode}, 32'd0);
        unlock(8'hA0, 1'b1);
        chk(burst_mode, "R3 bit0 ignored", {31'd0, burst_mode}, 32'd1);
        wr(K1, 16'h00F0);

        // R12 idle gaps
        wr(K1, 16'h00AA);
        repeat (6) @(negedge clk);
        wr(K2, 16'h0055);
        repeat (9) @(negedge clk);
        wr(K1, 16'h00A0);
        chk(burst_mode, "R12 idle gaps tolerated", {31'd0, burst_mode}, 32'd1);
        wr(K1, 16'h00F0);

        // R8 accesses while busy
        unlock(8'hA0, 1'b0);
        for (int i = 0; i < BW; i++) wr({2'd0, 2'(i), 1'b0}, 16'h3C3C);
        wr(K1, 16'h00B0);
        rd(5'h00, d, v);
        chk(!v, "R8 read refused while busy", {31'd0, v}, 32'd0);
        wr(K1, 16'h00AA);
        wait_idle(n);
        for (int i = 0; i < BW; i++) mdl[i] &= 16'h3C3C;
        wr(K2, 16'h0055);
        wr(K1, 16'h00A0);
        chk(!burst_mode, "R8 write ignored while busy", {31'd0, burst_mode}, 32'd0);
        sweep("R8 final sweep");

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog act=hung exp=complete");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule